// File: doc/BRIEF.md
# Dual Interval Timer Interrupt Unit

This block is a register-mapped peripheral. It holds two 16-bit down-counters with their reload latches, a mode register, an interrupt flag register and an interrupt enable register. A host reaches the registers over a byte-wide read/write port. The register index is taken from a field of the bus address. The counters move only on cycles where the tick enable input is high, so the tick rate is set outside the block.

Timer A can run free (continuous) or one-shot. In continuous mode it counts from its latch value down through zero to all-ones and then reloads, so one period is latch plus two ticks. Timer B is one-shot only. Each timer raises its flag when its count reaches zero. An external pulse input sets a third flag, the data-shift flag. The single interrupt request output combines the timer A flag and the shift flag with their enables. The timer B flag is visible only by reading the flag register.

Top module: `dual_timer_unit`

## Requirements
- R1: After reset, timer A counter and latch read 0xFFFF, timer B counter reads 0xFFFF, timer B latch is 0, the mode register is 0, the flag register reads 0x00, the enable register reads 0x80 and irq is low.
- R2: The register index is bus_addr[12:9]; other address bits are ignored. Index map: 0 timer A count low, 1 timer A count high, 2 timer A latch low, 3 timer A latch high, 4 timer B count low, 5 timer B count high, 6 mode, 7 flags, 8 enables; every other index reads 0.
- R3: A write to index 0 or index 2 changes only the low byte of the timer A latch; the counter keeps its value.
- R4: A write to index 1 sets the timer A latch high byte and loads the whole counter from the new latch value.
- R5: A write to index 3 sets the timer A latch high byte without touching the counter.
- R6: With mode bits 7:6 equal to 01, timer A counts latch, ..., 0, 0xFFFF, then reloads the latch. Its flag (bit 6) is set each time the count reaches 0, so the period is latch + 2 ticks.
- R7: With any other value in mode bits 7:6, timer A sets its flag once per load and then wraps from 0 to 0xFFFF and on without reloading.
- R8: A write to index 4 stores the timer B low latch. A write to index 5 loads the counter with {data, low latch}, arms one flag event (bit 5) at zero, and clears the timer B flag.
- R9: A write to index 8 with bit 7 set ORs bits 6:0 into the enables; with bit 7 clear it clears the enables named in bits 6:0. Reading index 8 returns bit 7 as 1.
- R10: Flag positions are shift 0x04, timer B 0x20 and timer A 0x40. The shift flag is set by sr_pulse. Writing 1 to a flag bit clears it. Reading index 7 returns bit 7 as the OR of all enabled set flags.
- R11: irq is high exactly when (flags & enables & 0x44) is nonzero.
- R12: A read of index 0 clears the timer A flag; a read of index 4 clears the timer B flag.
- R13: Counters change only on cycles with tick_en high or on a count-high write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 13 | Byte address; bits 12:9 select the register |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Register read strobe (drives read side effects) |
| rd_data | output | 8 | Read data, combinational from the selected register |
| tick_en | input | 1 | Counter tick enable |
| sr_pulse | input | 1 | Sets the data-shift interrupt flag |
| irq | output | 1 | Interrupt request, active high |

## Verification
The bench builds the block with its default parameters: a 13-bit address whose index sits in bits 12:9, and 16-bit counters. Small latch values bring the continuous reload through 0xFFFF, the one-shot wrap and the four-tick period within a few cycles. The same setup covers the flag set and clear paths and the interrupt mask, which ignores timer B, and the address bits below the index field are driven to all ones to show they are ignored.

// File: rtl/dtu_pkg.sv
package dtu_pkg;
  localparam int DATA_W = 8;

  typedef enum logic [3:0] {
    IDX_TA_CLO = 4'd0,
    IDX_TA_CHI = 4'd1,
    IDX_TA_LLO = 4'd2,
    IDX_TA_LHI = 4'd3,
    IDX_TB_CLO = 4'd4,
    IDX_TB_CHI = 4'd5,
    IDX_MODE   = 4'd6,
    IDX_FLAG   = 4'd7,
    IDX_ENAB   = 4'd8
  } reg_idx_e;

  localparam int FLG_SR = 2;
  localparam int FLG_TB = 5;
  localparam int FLG_TA = 6;

  localparam logic [1:0] TA_MODE_FREE = 2'b01;
endpackage

// File: rtl/dtu_rst_sync.sv
module dtu_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/dtu_down_timer.sv
module dtu_down_timer #(
  parameter int              CNT_W      = 16,
  parameter logic [CNT_W-1:0] LATCH_RST = '1,
  parameter bit              HAS_RELOAD = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick_en,
  input  logic               free_mode,
  input  logic               lat_lo_we,
  input  logic               lat_hi_we,
  input  logic               load_we,
  input  logic [CNT_W/2-1:0] wr_byte,
  output logic [CNT_W-1:0]   cnt_q,
  output logic [CNT_W-1:0]   lat_q,
  output logic               zero_evt
);
  localparam int HALF = CNT_W / 2;

  logic [CNT_W-1:0] cnt_d, lat_d;
  logic             arm_q, arm_d;
  logic             reload_ok;
  logic             cnt_en, lat_en;

  generate
    if (HAS_RELOAD) begin : g_reload
      assign reload_ok = free_mode;
    end else begin : g_oneshot
      assign reload_ok = 1'b0 & free_mode;
    end
  endgenerate

  assign cnt_en = load_we | tick_en;
  assign lat_en = lat_lo_we | lat_hi_we | load_we;

  always_comb begin
    lat_d    = lat_q;
    cnt_d    = cnt_q;
    arm_d    = arm_q;
    zero_evt = 1'b0;
    if (lat_lo_we)             lat_d[HALF-1:0]     = wr_byte;
    if (lat_hi_we || load_we)  lat_d[CNT_W-1:HALF] = wr_byte;
    if (load_we) begin
      cnt_d = {wr_byte, lat_q[HALF-1:0]};
      arm_d = 1'b1;
    end else if (tick_en) begin
      if (reload_ok && (cnt_q == '1)) cnt_d = lat_q;
      else                            cnt_d = cnt_q - 1'b1;
      if ((cnt_d == '0) && (reload_ok || arm_q)) begin
        zero_evt = 1'b1;
        if (!reload_ok) arm_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '1;
      lat_q <= LATCH_RST;
      arm_q <= 1'b0;
    end else begin
      if (cnt_en) begin
        cnt_q <= cnt_d;
        arm_q <= arm_d;
      end
      if (lat_en) lat_q <= lat_d;
    end
  end
endmodule

// File: rtl/dtu_irq_ctrl.sv
module dtu_irq_ctrl #(
  parameter int               FLG_W    = 7,
  parameter logic [FLG_W-1:0] IRQ_MASK = 7'h44
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [FLG_W-1:0] set_vec,
  input  logic [FLG_W-1:0] clr_vec,
  input  logic             ena_we,
  input  logic [FLG_W:0]   ena_wdata,
  output logic [FLG_W-1:0] flg_q,
  output logic [FLG_W-1:0] ena_q,
  output logic             irq
);
  logic [FLG_W-1:0] flg_d, ena_d;
  logic             flg_en;

  assign flg_en = |set_vec | |clr_vec;

  always_comb begin
    flg_d = (flg_q & ~clr_vec) | set_vec;
    ena_d = ena_q;
    if (ena_wdata[FLG_W]) ena_d = ena_q | ena_wdata[FLG_W-1:0];
    else                  ena_d = ena_q & ~ena_wdata[FLG_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flg_q <= '0;
      ena_q <= '0;
    end else begin
      if (flg_en) flg_q <= flg_d;
      if (ena_we) ena_q <= ena_d;
    end
  end

  assign irq = |(flg_q & ena_q & IRQ_MASK);
endmodule

// File: rtl/dual_timer_unit.sv
module dual_timer_unit
  import dtu_pkg::*;
#(
  parameter int IDX_LSB = 9,
  parameter int IDX_W   = 4,
  parameter int CNT_W   = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [IDX_LSB+IDX_W-1:0] bus_addr,
  input  logic                     wr_en,
  input  logic [DATA_W-1:0]        wr_data,
  input  logic                     rd_en,
  output logic [DATA_W-1:0]        rd_data,
  input  logic                     tick_en,
  input  logic                     sr_pulse,
  output logic                     irq
);
  localparam int FLG_W = DATA_W - 1;
  localparam int HALF  = CNT_W / 2;

  logic             rst_sync_n;
  logic [IDX_W-1:0] idx;
  logic             unused_addr_bits;

  logic [CNT_W-1:0] ta_cnt, ta_lat, tb_cnt, tb_lat_unused;
  logic             ta_evt, tb_evt;
  logic [DATA_W-1:0] mode_q, mode_d;
  logic             ta_free;
  logic [FLG_W-1:0] set_vec, clr_vec, flg_q, ena_q;

  logic w_ta_clo, w_ta_chi, w_ta_llo, w_ta_lhi, w_tb_clo, w_tb_chi;
  logic w_mode, w_flag, w_enab, r_ta_clo, r_tb_clo;

  dtu_rst_sync #(.STAGES(2)) u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_sync_n(rst_sync_n)
  );

  assign idx              = bus_addr[IDX_LSB+IDX_W-1:IDX_LSB];
  assign unused_addr_bits = ^bus_addr[IDX_LSB-1:0];

  assign w_ta_clo = wr_en && (idx == IDX_W'(IDX_TA_CLO));
  assign w_ta_chi = wr_en && (idx == IDX_W'(IDX_TA_CHI));
  assign w_ta_llo = wr_en && (idx == IDX_W'(IDX_TA_LLO));
  assign w_ta_lhi = wr_en && (idx == IDX_W'(IDX_TA_LHI));
  assign w_tb_clo = wr_en && (idx == IDX_W'(IDX_TB_CLO));
  assign w_tb_chi = wr_en && (idx == IDX_W'(IDX_TB_CHI));
  assign w_mode   = wr_en && (idx == IDX_W'(IDX_MODE));
  assign w_flag   = wr_en && (idx == IDX_W'(IDX_FLAG));
  assign w_enab   = wr_en && (idx == IDX_W'(IDX_ENAB));
  assign r_ta_clo = rd_en && (idx == IDX_W'(IDX_TA_CLO));
  assign r_tb_clo = rd_en && (idx == IDX_W'(IDX_TB_CLO));

  // Mode register: next-state and storage
  always_comb begin
    mode_d = mode_q;
    if (w_mode) mode_d = wr_data;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  mode_q <= '0;
    else if (w_mode)  mode_q <= mode_d;
  end

  assign ta_free = (mode_q[DATA_W-1:DATA_W-2] == TA_MODE_FREE);

  dtu_down_timer #(
    .CNT_W     (CNT_W),
    .LATCH_RST ('1),
    .HAS_RELOAD(1'b1)
  ) u_timer_a (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .tick_en  (tick_en),
    .free_mode(ta_free),
    .lat_lo_we(w_ta_clo | w_ta_llo),
    .lat_hi_we(w_ta_lhi),
    .load_we  (w_ta_chi),
    .wr_byte  (wr_data[HALF-1:0]),
    .cnt_q    (ta_cnt),
    .lat_q    (ta_lat),
    .zero_evt (ta_evt)
  );

  dtu_down_timer #(
    .CNT_W     (CNT_W),
    .LATCH_RST ('0),
    .HAS_RELOAD(1'b0)
  ) u_timer_b (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .tick_en  (tick_en),
    .free_mode(1'b0),
    .lat_lo_we(w_tb_clo),
    .lat_hi_we(1'b0),
    .load_we  (w_tb_chi),
    .wr_byte  (wr_data[HALF-1:0]),
    .cnt_q    (tb_cnt),
    .lat_q    (tb_lat_unused),
    .zero_evt (tb_evt)
  );

  always_comb begin
    set_vec         = '0;
    set_vec[FLG_SR] = sr_pulse;
    set_vec[FLG_TB] = tb_evt;
    set_vec[FLG_TA] = ta_evt;
    clr_vec         = w_flag ? wr_data[FLG_W-1:0] : '0;
    if (r_ta_clo)              clr_vec[FLG_TA] = 1'b1;
    if (r_tb_clo || w_tb_chi)  clr_vec[FLG_TB] = 1'b1;
  end

  dtu_irq_ctrl #(
    .FLG_W   (FLG_W),
    .IRQ_MASK(FLG_W'((1 << FLG_SR) | (1 << FLG_TA)))
  ) u_irq (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .set_vec  (set_vec),
    .clr_vec  (clr_vec),
    .ena_we   (w_enab),
    .ena_wdata(wr_data),
    .flg_q    (flg_q),
    .ena_q    (ena_q),
    .irq      (irq)
  );

  // Read mux
  always_comb begin
    rd_data = '0;
    if (rd_en) begin
      case (idx)
        IDX_W'(IDX_TA_CLO): rd_data = ta_cnt[HALF-1:0];
        IDX_W'(IDX_TA_CHI): rd_data = ta_cnt[CNT_W-1:HALF];
        IDX_W'(IDX_TA_LLO): rd_data = ta_lat[HALF-1:0];
        IDX_W'(IDX_TA_LHI): rd_data = ta_lat[CNT_W-1:HALF];
        IDX_W'(IDX_TB_CLO): rd_data = tb_cnt[HALF-1:0];
        IDX_W'(IDX_TB_CHI): rd_data = tb_cnt[CNT_W-1:HALF];
        IDX_W'(IDX_MODE):   rd_data = mode_q;
        IDX_W'(IDX_FLAG):   rd_data = {|(flg_q & ena_q), flg_q};
        IDX_W'(IDX_ENAB):   rd_data = {1'b1, ena_q};
        default:            rd_data = '0;
      endcase
    end
  end
endmodule

// File: rtl/dtu_checker.sv
module dtu_checker #(
  parameter int IDX_LSB = 9,
  parameter int IDX_W   = 4,
  parameter int CNT_W   = 16,
  parameter int DATA_W  = 8
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [IDX_LSB+IDX_W-1:0] bus_addr,
  input logic                     wr_en,
  input logic [DATA_W-1:0]        wr_data,
  input logic                     rd_en,
  input logic [DATA_W-1:0]        rd_data,
  input logic                     tick_en,
  input logic                     sr_pulse,
  input logic [CNT_W-1:0]         ta_cnt,
  input logic [CNT_W-1:0]         ta_lat,
  input logic [CNT_W-1:0]         tb_cnt,
  input logic [DATA_W-1:0]        mode_q,
  input logic [DATA_W-2:0]        flg_q,
  input logic [DATA_W-2:0]        ena_q
);
  localparam int HALF = CNT_W / 2;
  logic [IDX_W-1:0] idx;
  assign idx = bus_addr[IDX_LSB+IDX_W-1:IDX_LSB];

  // R9
  ena_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && idx == IDX_W'(8) && wr_data[DATA_W-1])
    |=> ((ena_q & $past(wr_data[DATA_W-2:0])) == $past(wr_data[DATA_W-2:0])));

  // R9
  ena_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && idx == IDX_W'(8)) |-> rd_data[DATA_W-1]);

  // R13
  count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !wr_en) |=> ($stable(ta_cnt) && $stable(tb_cnt)));

  // R4
  ta_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && idx == IDX_W'(1))
    |=> (ta_cnt == {$past(wr_data[HALF-1:0]), $past(ta_lat[HALF-1:0])}));

  // R6
  ta_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && !wr_en && mode_q[DATA_W-1:DATA_W-2] == 2'b01 && ta_cnt == '1)
    |=> (ta_cnt == $past(ta_lat)));

  // R10
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && idx == IDX_W'(7) && wr_data[2] && !sr_pulse) |=> !flg_q[2]);
endmodule

bind dual_timer_unit dtu_checker #(
  .IDX_LSB(IDX_LSB),
  .IDX_W  (IDX_W),
  .CNT_W  (CNT_W),
  .DATA_W (8)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_sync_n),
  .bus_addr(bus_addr),
  .wr_en   (wr_en),
  .wr_data (wr_data),
  .rd_en   (rd_en),
  .rd_data (rd_data),
  .tick_en (tick_en),
  .sr_pulse(sr_pulse),
  .ta_cnt  (ta_cnt),
  .ta_lat  (ta_lat),
  .tb_cnt  (tb_cnt),
  .mode_q  (mode_q),
  .flg_q   (flg_q),
  .ena_q   (ena_q)
);

// File: tb/dual_timer_unit_bench.sv
module dual_timer_unit_bench;
  logic        clk;
  logic        rst_n;
  logic [12:0] bus_addr;
  logic        wr_en;
  logic [7:0]  wr_data;
  logic        rd_en;
  logic [7:0]  rd_data;
  logic        tick_en;
  logic        sr_pulse;
  logic        irq;

  int checks;
  int errors;
  bit done;

  dual_timer_unit u_dual_timer_unit (
    .clk     (clk),
    .rst_n   (rst_n),
    .bus_addr(bus_addr),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .rd_en   (rd_en),
    .rd_data (rd_data),
    .tick_en (tick_en),
    .sr_pulse(sr_pulse),
    .irq     (irq)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // {req[3:0], is_read, idx[3:0], data_or_expected[7:0]}
  localparam int NVEC = 19;
  localparam logic [16:0] VEC [NVEC] = '{
    // R1 reset values
    {4'd1, 1'b1, 4'd0, 8'hFF}, {4'd1, 1'b1, 4'd1, 8'hFF},
    {4'd1, 1'b1, 4'd2, 8'hFF}, {4'd1, 1'b1, 4'd3, 8'hFF},
    {4'd1, 1'b1, 4'd4, 8'hFF}, {4'd1, 1'b1, 4'd5, 8'hFF},
    {4'd1, 1'b1, 4'd7, 8'h00}, {4'd1, 1'b1, 4'd8, 8'h80},
    // R3 low-byte latch writes
    {4'd3, 1'b0, 4'd0, 8'h05}, {4'd3, 1'b1, 4'd2, 8'h05},
    {4'd3, 1'b1, 4'd0, 8'hFF}, {4'd3, 1'b0, 4'd2, 8'h03},
    {4'd3, 1'b1, 4'd2, 8'h03},
    // R5 latch-high write without reload
    {4'd5, 1'b0, 4'd3, 8'h00}, {4'd5, 1'b1, 4'd3, 8'h00},
    {4'd5, 1'b1, 4'd1, 8'hFF},
    // R4 count-high write loads the counter
    {4'd4, 1'b0, 4'd1, 8'h00}, {4'd4, 1'b1, 4'd0, 8'h03},
    {4'd4, 1'b1, 4'd1, 8'h00}
  };

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic wr_addr(input logic [12:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wr(input logic [3:0] i, input logic [7:0] d);
    wr_addr({i, 9'h000}, d);
  endtask

  task automatic rd_addr(input logic [12:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    bus_addr = a; rd_en = 1'b1;
    #1 check(rd_data, exp, tag);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] i, input logic [7:0] exp, input string tag);
    rd_addr({i, 9'h000}, exp, tag);
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tick_en = 1'b1;
    repeat (n) @(negedge clk);
    tick_en = 1'b0;
  endtask

  task automatic pulse_sr();
    @(negedge clk);
    sr_pulse = 1'b1;
    @(negedge clk);
    sr_pulse = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    checks = 0; errors = 0; done = 1'b0;
    bus_addr = '0; wr_en = 0; wr_data = '0; rd_en = 0; tick_en = 0; sr_pulse = 0;
    do_reset();
    check({7'd0, irq}, 8'h00, "R1 irq after reset");

    for (int k = 0; k < NVEC; k++) begin
      if (VEC[k][12]) rd(VEC[k][11:8], VEC[k][7:0], $sformatf("R%0d vector %0d", VEC[k][16:13], k));
      else            wr(VEC[k][11:8], VEC[k][7:0]);
    end

    // R9 enable set, read shows bit 7
    wr(4'd8, 8'hC0);
    rd(4'd8, 8'hC0, "R9 enable set");

    // R13 no tick, no change
    repeat (5) @(negedge clk);
    rd(4'd0, 8'h03, "R13 counter held without tick");

    // R7 one-shot timer A
    ticks(2);
    check({7'd0, irq}, 8'h00, "R7 no irq before zero");
    ticks(1);
    check({7'd0, irq}, 8'h01, "R11 irq on timer A zero");
    rd(4'd7, 8'hC0, "R10 flag read with summary bit");
    rd(4'd0, 8'h00, "R7 counter at zero");
    check({7'd0, irq}, 8'h00, "R12 read low clears timer A flag");
    rd(4'd7, 8'h00, "R12 flag cleared");
    ticks(2);
    rd(4'd1, 8'hFF, "R7 wrap high");
    rd(4'd0, 8'hFE, "R7 wrap low, no reload");
    rd(4'd7, 8'h00, "R7 single event per load");

    // R6 continuous timer A, latch 2
    wr(4'd6, 8'h40);
    wr(4'd2, 8'h02);
    wr(4'd1, 8'h00);
    ticks(2);
    check({7'd0, irq}, 8'h01, "R6 flag at zero");
    wr(4'd7, 8'h40);
    rd(4'd7, 8'h00, "R10 write one clears flag");
    ticks(1);
    rd(4'd1, 8'hFF, "R6 passes through all-ones");
    ticks(1);
    rd(4'd0, 8'h02, "R6 reload from latch");
    ticks(2);
    check({7'd0, irq}, 8'h01, "R6 period latch plus two");
    wr(4'd6, 8'h00);
    wr(4'd1, 8'hFF);
    wr(4'd7, 8'h7F);
    rd(4'd7, 8'h00, "R10 clear all flags");
    wr(4'd8, 8'h40);
    rd(4'd8, 8'h80, "R9 enable clear");

    // R8 timer B
    wr(4'd4, 8'h02);
    wr(4'd5, 8'h00);
    wr(4'd8, 8'hA0);
    rd(4'd8, 8'hA0, "R9 enable timer B");
    ticks(2);
    rd(4'd7, 8'hA0, "R8 timer B flag at zero");
    check({7'd0, irq}, 8'h00, "R11 timer B not in irq");
    rd(4'd4, 8'h00, "R8 timer B counter zero");
    rd(4'd7, 8'h00, "R12 read clears timer B flag");
    ticks(2);
    rd(4'd5, 8'hFF, "R8 timer B wrap high");
    rd(4'd4, 8'hFE, "R8 timer B wrap low");
    rd(4'd7, 8'h00, "R8 timer B one event");
    wr(4'd5, 8'h00);
    ticks(2);
    wr(4'd5, 8'h10);
    rd(4'd7, 8'h00, "R8 high write clears flag");
    rd(4'd5, 8'h10, "R8 high byte loaded");
    rd(4'd4, 8'h02, "R8 low latch used");

    // R10 shift flag
    wr(4'd8, 8'h84);
    pulse_sr();
    check({7'd0, irq}, 8'h01, "R11 shift flag raises irq");
    rd(4'd7, 8'h84, "R10 shift flag position");
    wr(4'd7, 8'h04);
    check({7'd0, irq}, 8'h00, "R10 shift flag cleared");
    wr(4'd8, 8'h04);
    pulse_sr();
    rd(4'd7, 8'h04, "R10 summary bit needs enable");
    check({7'd0, irq}, 8'h00, "R11 disabled flag no irq");

    // R2 address field
    wr_addr({4'd6, 9'h1FF}, 8'h5A);
    rd(4'd6, 8'h5A, "R2 low address bits ignored");
    rd(4'd15, 8'h00, "R2 unused index reads zero");

    // R1 reset mid-run
    do_reset();
    rd(4'd0, 8'hFF, "R1 counter after reset");
    rd(4'd3, 8'hFF, "R1 latch after reset");
    rd(4'd6, 8'h00, "R1 mode after reset");
    rd(4'd7, 8'h00, "R1 flags after reset");
    rd(4'd8, 8'h80, "R1 enables after reset");
    check({7'd0, irq}, 8'h00, "R1 irq low");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule